// File: doc/BRIEF.md
# Two-Wire Master Register Front End

This block is the software-facing side of a two-wire serial master. A 32-bit register bus reads and writes the timing settings for the standard/fast and high-speed bus modes, a bus configuration word, a target address, a 64-bit data window and the interrupt controls. A single write to the command word starts a complete transfer: write only, read only, or write followed by a repeated-start read. Each direction moves from one to eight bytes.

Once a transfer starts, the block hands its type, lengths, target address and transmit payload to a separate bit-level engine and waits for that engine to report the end of the transfer. It then records the outcome as sticky status flags, clears its busy indication and, on a clean read, stores the received bytes in the data window. The interrupt line is a level output that reflects the status flags that are enabled in the interrupt mask.

Register reads return data in the same cycle the address is presented. A write takes effect at the clock edge on which the write strobe is sampled.

Top module: `twm_regfront`

## Requirements
- R1: After reset, both clock words (0x00 standard/fast, 0x04 high-speed) read 0x301F, the configuration word (0x08) reads 0x3302, and the command (0x0C), address (0x10), data (0x14, 0x18), status (0x1C), mask (0x20) and busy (0x24) words all read 0.
- R2: Each clock word keeps a 4-bit filter in bits 15:12 and a 10-bit divider in bits 9:0. The configuration word keeps the arbitration filter in 15:12, the NAK count in 11:8, the 10-bit address enable in bit 7, the high-speed master code in 6:4, the arbitration enable in bit 1 and the high-speed enable in bit 0. All other bits read 0.
- R3: The command word has the type in bits 9:8 (0 = write, 1 = read, 2 = write then read), the write length minus one in 6:4 and the read length minus one in 2:0. Writing it while idle makes the busy word read 1 and produces a one-cycle `eng_start` pulse that carries those fields.
- R4: A command write is ignored when the block is busy, and also when its type field is 3. In either case there is no start pulse and the command word keeps its previous value.
- R5: When `eng_done` arrives while busy, the busy word returns to 0 and, on the same edge, status bit 0 (done) is set together with the error flags: `eng_flags[0]` sets bit 1 (lost arbitration), `[1]` sets bit 2 (no response), `[2]` sets bit 3 (data collision) and `[3]` sets bit 4 (bus busy).
- R6: Writing the status word clears each bit that is written as 1 and leaves the bits written as 0 unchanged. When a completion and a clearing write fall on the same edge, the completion wins.
- R7: `irq` is high exactly when some status bit and its matching mask bit are both set. The mask occupies bits 4:0 of 0x20.
- R8: `eng_wdata` presents the data window as {high word, low word}. The transmit bytes are right-justified, so the first byte sent is the most significant valid byte.
- R9: When a read or write-then-read finishes with no error flag, the data window takes `eng_rdata` right-justified and masked to the read length. All bytes above the read length read 0. A finished write-only transfer leaves the data window unchanged.
- R10: When a transfer finishes with any error flag set, the data window keeps its previous contents.
- R11: The address word is 10 bits wide. `eng_addr` carries all 10 bits when the 10-bit address enable is set, and only the low 7 bits, with bits 9:7 forced to 0, when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | One-cycle transfer launch |
| eng_kind | output | 2 | Transfer type |
| eng_wlen_m1 | output | 3 | Write length minus one |
| eng_rlen_m1 | output | 3 | Read length minus one |
| eng_addr | output | 10 | Target address after width select |
| eng_wdata | output | 64 | Transmit payload |
| eng_done | input | 1 | Engine completion pulse |
| eng_flags | input | 4 | Error flags, valid with eng_done |
| eng_rdata | input | 64 | Received payload, valid with eng_done |
| std_filt | output | 4 | Standard/fast glitch filter |
| std_div | output | 10 | Standard/fast clock divider |
| hs_filt | output | 4 | High-speed glitch filter |
| hs_div | output | 10 | High-speed clock divider |
| arb_filt | output | 4 | Arbitration filter |
| nak_cnt | output | 4 | NAK count |
| addr10_en | output | 1 | 10-bit address enable |
| hs_mcode | output | 3 | High-speed master code |
| arb_en | output | 1 | Arbitration enable |
| hs_en | output | 1 | High-speed mode enable |

## Verification
The bench targets the read-length mask: a design that copied the whole engine word would show stray high bytes after a one- or two-byte read. It launches a second command in the middle of a long transfer and also writes type 3. A block that accepted either would emit an extra start pulse or overwrite the command word. It completes transfers with error flags and checks that the data window is left alone, since partial receive data must not leak into it. It also clears the status bits selectively and checks the masked interrupt and the narrowing of the address to 7 bits, which would expose a misplaced status bit or an address that always drives 10 bits.

// File: rtl/twm_pkg.sv
package twm_pkg;

    localparam int BUS_W     = 32;
    localparam int REG_AW    = 8;
    localparam int SADDR_W   = 10;
    localparam int SADDR7_W  = 7;
    localparam int MAX_BYTES = 8;
    localparam int LEN_W     = $clog2(MAX_BYTES);
    localparam int PAYLOAD_W = MAX_BYTES * 8;
    localparam int N_WORDS   = PAYLOAD_W / BUS_W;
    localparam int N_FLAGS   = 4;
    localparam int STS_W     = N_FLAGS + 1;
    localparam int FILT_W    = 4;
    localparam int DIV_W     = 10;
    localparam int N_CLKREG  = 2;

    localparam logic [REG_AW-1:0] OFF_CLK_STD = 8'h00;
    localparam logic [REG_AW-1:0] OFF_CLK_HS  = 8'h04;
    localparam logic [REG_AW-1:0] OFF_CFG     = 8'h08;
    localparam logic [REG_AW-1:0] OFF_CMD     = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_ADDR    = 8'h10;
    localparam logic [REG_AW-1:0] OFF_DLO     = 8'h14;
    localparam logic [REG_AW-1:0] OFF_DHI     = 8'h18;
    localparam logic [REG_AW-1:0] OFF_STS     = 8'h1C;
    localparam logic [REG_AW-1:0] OFF_MASK    = 8'h20;
    localparam logic [REG_AW-1:0] OFF_BUSY    = 8'h24;

    typedef enum logic [1:0] {
        XFER_WR   = 2'd0,
        XFER_RD   = 2'd1,
        XFER_WRRD = 2'd2,
        XFER_RSVD = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic [FILT_W-1:0] filt;
        logic [DIV_W-1:0]  div;
    } clkcfg_t;

    typedef struct packed {
        logic [3:0] arb_filt;
        logic [3:0] nak_cnt;
        logic       addr10;
        logic [2:0] mcode;
        logic       arb_en;
        logic       hs_en;
    } buscfg_t;

    typedef struct packed {
        xfer_kind_e       kind;
        logic [LEN_W-1:0] wlen_m1;
        logic [LEN_W-1:0] rlen_m1;
    } cmd_t;

    localparam clkcfg_t CLK_RST = '{filt: 4'h3, div: 10'h01F};
    localparam buscfg_t CFG_RST = '{arb_filt: 4'h3, nak_cnt: 4'h3, addr10: 1'b0,
                                    mcode: 3'h0, arb_en: 1'b1, hs_en: 1'b0};
    localparam cmd_t    CMD_RST = '{kind: XFER_WR, wlen_m1: '0, rlen_m1: '0};

    function automatic logic [BUS_W-1:0] clk_word(input clkcfg_t c);
        return {16'b0, c.filt, 2'b0, c.div};
    endfunction

    function automatic logic [BUS_W-1:0] cfg_word(input buscfg_t c);
        return {16'b0, c.arb_filt, c.nak_cnt, c.addr10, c.mcode, 2'b0, c.arb_en, c.hs_en};
    endfunction

    function automatic logic [BUS_W-1:0] cmd_word(input cmd_t c);
        return {22'b0, c.kind, 1'b0, c.wlen_m1, 1'b0, c.rlen_m1};
    endfunction

    function automatic logic [PAYLOAD_W-1:0] byte_mask(input logic [LEN_W-1:0] len_m1);
        logic [PAYLOAD_W-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (i <= int'(len_m1)) m[i*8 +: 8] = 8'hFF;
        end
        return m;
    endfunction

endpackage

// File: rtl/twm_cfg_regs.sv
module twm_cfg_regs
    import twm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [N_CLKREG-1:0] clk_wr,
    input  clkcfg_t             clk_wval,
    input  logic                cfg_wr,
    input  buscfg_t             cfg_wval,
    output clkcfg_t             std_q,
    output clkcfg_t             hs_q,
    output buscfg_t             cfg_q
);

    for (genvar g = 0; g < N_CLKREG; g++) begin : g_clk
        clkcfg_t q;
        always_ff @(posedge clk) begin
            if (rst)            q <= CLK_RST;
            else if (clk_wr[g]) q <= clk_wval;
        end
    end

    assign std_q = g_clk[0].q;
    assign hs_q  = g_clk[1].q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= CFG_RST;
        else if (cfg_wr) cfg_q <= cfg_wval;
    end

endmodule

// File: rtl/twm_xfer_ctrl.sv
module twm_xfer_ctrl
    import twm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    input  cmd_t cmd_wval,
    input  logic eng_done,
    output cmd_t cmd_q,
    output logic busy_q,
    output logic start_q,
    output logic done_evt
);

    logic launch_ok;

    assign launch_ok = cmd_wr && !busy_q && (cmd_wval.kind != XFER_RSVD);
    assign done_evt  = eng_done && busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= CMD_RST;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= launch_ok;
            if (launch_ok) begin
                cmd_q  <= cmd_wval;
                busy_q <= 1'b1;
            end else if (done_evt) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/twm_stat_irq.sv
module twm_stat_irq
    import twm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sts_wr,
    input  logic               mask_wr,
    input  logic [STS_W-1:0]   wval,
    input  logic               done_evt,
    input  logic [N_FLAGS-1:0] flags,
    output logic [STS_W-1:0]   sts_q,
    output logic [STS_W-1:0]   mask_q,
    output logic               irq
);

    logic [STS_W-1:0] clr_bits;
    logic [STS_W-1:0] set_bits;

    assign clr_bits = sts_wr   ? wval : '0;
    assign set_bits = done_evt ? {flags, 1'b1} : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q  <= '0;
            mask_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_bits) | set_bits;
            if (mask_wr) mask_q <= wval;
        end
    end

    assign irq = |(sts_q & mask_q);

endmodule

// File: rtl/twm_data_regs.sv
module twm_data_regs
    import twm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 addr_wr,
    input  logic [SADDR_W-1:0]   addr_wval,
    input  logic [N_WORDS-1:0]   word_wr,
    input  logic [BUS_W-1:0]     word_wval,
    input  logic                 capture,
    input  logic [LEN_W-1:0]     rlen_m1,
    input  logic [PAYLOAD_W-1:0] rx_data,
    output logic [SADDR_W-1:0]   addr_q,
    output logic [PAYLOAD_W-1:0] data_q
);

    logic [PAYLOAD_W-1:0] rx_masked;

    assign rx_masked = rx_data & byte_mask(rlen_m1);

    always_ff @(posedge clk) begin
        if (rst)          addr_q <= '0;
        else if (addr_wr) addr_q <= addr_wval;
    end

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        logic [BUS_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)             q <= '0;
            else if (capture)    q <= rx_masked[w*BUS_W +: BUS_W];
            else if (word_wr[w]) q <= word_wval;
        end
        assign data_q[w*BUS_W +: BUS_W] = q;
    end

endmodule

// File: rtl/twm_regfront.sv
module twm_regfront
    import twm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [REG_AW-1:0]      bus_addr,
    input  logic [BUS_W-1:0]       bus_wdata,
    output logic [BUS_W-1:0]       bus_rdata,
    output logic                   irq,
    output logic                   eng_start,
    output logic [1:0]             eng_kind,
    output logic [LEN_W-1:0]       eng_wlen_m1,
    output logic [LEN_W-1:0]       eng_rlen_m1,
    output logic [SADDR_W-1:0]     eng_addr,
    output logic [PAYLOAD_W-1:0]   eng_wdata,
    input  logic                   eng_done,
    input  logic [N_FLAGS-1:0]     eng_flags,
    input  logic [PAYLOAD_W-1:0]   eng_rdata,
    output logic [FILT_W-1:0]      std_filt,
    output logic [DIV_W-1:0]       std_div,
    output logic [FILT_W-1:0]      hs_filt,
    output logic [DIV_W-1:0]       hs_div,
    output logic [3:0]             arb_filt,
    output logic [3:0]             nak_cnt,
    output logic                   addr10_en,
    output logic [2:0]             hs_mcode,
    output logic                   arb_en,
    output logic                   hs_en
);

    // Write decode
    logic                clk_std_wr, clk_hs_wr, cfg_wr, cmd_wr, addr_wr;
    logic                sts_wr, mask_wr;
    logic [N_WORDS-1:0]  word_wr;

    assign clk_std_wr = bus_wr && (bus_addr == OFF_CLK_STD);
    assign clk_hs_wr  = bus_wr && (bus_addr == OFF_CLK_HS);
    assign cfg_wr     = bus_wr && (bus_addr == OFF_CFG);
    assign cmd_wr     = bus_wr && (bus_addr == OFF_CMD);
    assign addr_wr    = bus_wr && (bus_addr == OFF_ADDR);
    assign sts_wr     = bus_wr && (bus_addr == OFF_STS);
    assign mask_wr    = bus_wr && (bus_addr == OFF_MASK);
    assign word_wr    = {bus_wr && (bus_addr == OFF_DHI), bus_wr && (bus_addr == OFF_DLO)};

    // Field extraction from the write word
    clkcfg_t clk_wval;
    buscfg_t cfg_wval;
    cmd_t    cmd_wval;

    assign clk_wval = '{filt: bus_wdata[15:12], div: bus_wdata[9:0]};
    assign cfg_wval = '{arb_filt: bus_wdata[15:12], nak_cnt: bus_wdata[11:8],
                        addr10: bus_wdata[7], mcode: bus_wdata[6:4],
                        arb_en: bus_wdata[1], hs_en: bus_wdata[0]};
    assign cmd_wval = '{kind: xfer_kind_e'(bus_wdata[9:8]),
                        wlen_m1: bus_wdata[6:4], rlen_m1: bus_wdata[2:0]};

    clkcfg_t std_q, hs_q;
    buscfg_t cfg_q;

    twm_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .clk_wr   ({clk_hs_wr, clk_std_wr}),
        .clk_wval (clk_wval),
        .cfg_wr   (cfg_wr),
        .cfg_wval (cfg_wval),
        .std_q    (std_q),
        .hs_q     (hs_q),
        .cfg_q    (cfg_q)
    );

    cmd_t cmd_q;
    logic busy_q, done_evt;

    twm_xfer_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_wval (cmd_wval),
        .eng_done (eng_done),
        .cmd_q    (cmd_q),
        .busy_q   (busy_q),
        .start_q  (eng_start),
        .done_evt (done_evt)
    );

    logic [STS_W-1:0] sts_q, mask_q;

    twm_stat_irq u_stat (
        .clk      (clk),
        .rst      (rst),
        .sts_wr   (sts_wr),
        .mask_wr  (mask_wr),
        .wval     (bus_wdata[STS_W-1:0]),
        .done_evt (done_evt),
        .flags    (eng_flags),
        .sts_q    (sts_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    logic                 rx_capture;
    logic [SADDR_W-1:0]   addr_q;
    logic [PAYLOAD_W-1:0] data_q;

    assign rx_capture = done_evt && (eng_flags == '0) && (cmd_q.kind != XFER_WR);

    twm_data_regs u_data (
        .clk       (clk),
        .rst       (rst),
        .addr_wr   (addr_wr),
        .addr_wval (bus_wdata[SADDR_W-1:0]),
        .word_wr   (word_wr),
        .word_wval (bus_wdata),
        .capture   (rx_capture),
        .rlen_m1   (cmd_q.rlen_m1),
        .rx_data   (eng_rdata),
        .addr_q    (addr_q),
        .data_q    (data_q)
    );

    // Engine-facing outputs
    assign eng_kind    = cmd_q.kind;
    assign eng_wlen_m1 = cmd_q.wlen_m1;
    assign eng_rlen_m1 = cmd_q.rlen_m1;
    assign eng_wdata   = data_q;
    assign eng_addr    = cfg_q.addr10 ? addr_q
                                      : {{(SADDR_W-SADDR7_W){1'b0}}, addr_q[SADDR7_W-1:0]};

    assign std_filt  = std_q.filt;
    assign std_div   = std_q.div;
    assign hs_filt   = hs_q.filt;
    assign hs_div    = hs_q.div;
    assign arb_filt  = cfg_q.arb_filt;
    assign nak_cnt   = cfg_q.nak_cnt;
    assign addr10_en = cfg_q.addr10;
    assign hs_mcode  = cfg_q.mcode;
    assign arb_en    = cfg_q.arb_en;
    assign hs_en     = cfg_q.hs_en;

    // Read mux
    always_comb begin
        case (bus_addr)
            OFF_CLK_STD: bus_rdata = clk_word(std_q);
            OFF_CLK_HS:  bus_rdata = clk_word(hs_q);
            OFF_CFG:     bus_rdata = cfg_word(cfg_q);
            OFF_CMD:     bus_rdata = cmd_word(cmd_q);
            OFF_ADDR:    bus_rdata = {{(BUS_W-SADDR_W){1'b0}}, addr_q};
            OFF_DLO:     bus_rdata = data_q[0 +: BUS_W];
            OFF_DHI:     bus_rdata = data_q[BUS_W +: BUS_W];
            OFF_STS:     bus_rdata = {{(BUS_W-STS_W){1'b0}}, sts_q};
            OFF_MASK:    bus_rdata = {{(BUS_W-STS_W){1'b0}}, mask_q};
            OFF_BUSY:    bus_rdata = {{(BUS_W-1){1'b0}}, busy_q};
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/twm_regfront_chk.sv
module twm_regfront_chk
    import twm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cmd_wr,
    input logic               busy,
    input logic               eng_start,
    input logic               eng_done,
    input logic [STS_W-1:0]   sts,
    input logic [STS_W-1:0]   mask,
    input logic               irq,
    input buscfg_t            cfg,
    input logic [SADDR_W-1:0] eng_addr
);

    assert_cfg_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg == CFG_RST));

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    assert_busy_with_start_R3: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> busy);

    assert_ignore_when_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> !eng_start);

    assert_done_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (eng_done && busy) |=> (sts[0] && !busy));

    assert_mask_gates_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

    assert_addr7_R11: assert property (@(posedge clk) disable iff (rst)
        !cfg.addr10 |-> (eng_addr[SADDR_W-1:SADDR7_W] == '0));

endmodule

bind twm_regfront twm_regfront_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .busy      (busy_q),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .sts       (sts_q),
    .mask      (mask_q),
    .irq       (irq),
    .cfg       (cfg_q),
    .eng_addr  (eng_addr)
);

// File: tb/twm_regfront_bench.sv
module twm_regfront_bench;
    import twm_pkg::*;

    localparam time CLK_PERIOD = 20ns;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 bus_wr = 1'b0;
    logic [REG_AW-1:0]    bus_addr = '0;
    logic [BUS_W-1:0]     bus_wdata = '0;
    logic [BUS_W-1:0]     bus_rdata;
    logic                 irq, eng_start;
    logic [1:0]           eng_kind;
    logic [LEN_W-1:0]     eng_wlen_m1, eng_rlen_m1;
    logic [SADDR_W-1:0]   eng_addr;
    logic [PAYLOAD_W-1:0] eng_wdata;
    logic                 eng_done = 1'b0;
    logic [N_FLAGS-1:0]   eng_flags = '0;
    logic [PAYLOAD_W-1:0] eng_rdata = '0;
    logic [FILT_W-1:0]    std_filt, hs_filt;
    logic [DIV_W-1:0]     std_div, hs_div;
    logic [3:0]           arb_filt, nak_cnt;
    logic                 addr10_en, arb_en, hs_en;
    logic [2:0]           hs_mcode;

    always #(CLK_PERIOD/2) clk = ~clk;

    twm_regfront u_twm_regfront (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Responder state
    int                   n_start = 0;
    int                   resp_delay = 3;
    logic [N_FLAGS-1:0]   resp_flags = '0;
    logic [PAYLOAD_W-1:0] resp_data = '0;
    logic [1:0]           cap_kind;
    logic [LEN_W-1:0]     cap_wl, cap_rl;
    logic [PAYLOAD_W-1:0] cap_wd;

    initial begin
        forever begin
            @(negedge clk);
            if (eng_start) begin
                n_start++;
                cap_kind = eng_kind;
                cap_wl   = eng_wlen_m1;
                cap_rl   = eng_rlen_m1;
                cap_wd   = eng_wdata;
                repeat (resp_delay) @(negedge clk);
                eng_done  = 1'b1;
                eng_flags = resp_flags;
                eng_rdata = resp_data;
                @(negedge clk);
                eng_done  = 1'b0;
                eng_flags = '0;
                eng_rdata = '0;
            end
        end
    end

    typedef struct packed {
        logic [1:0]         kind;
        logic [2:0]         wl;
        logic [2:0]         rl;
        logic [3:0]         flg;
        logic [63:0]        wd;
        logic [63:0]        rsp;
        logic [63:0]        exp_d;
        logic [4:0]         exp_s;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd3, 3'd0, 4'b0000, 64'h0000_0000_1122_3344, 64'hDEAD_BEEF_0000_FFFF, 64'h0000_0000_1122_3344, 5'h01},
        '{2'd1, 3'd0, 3'd1, 4'b0000, 64'h0,                   64'hFFFF_FFFF_FFFF_A55A, 64'h0000_0000_0000_A55A, 5'h01},
        '{2'd2, 3'd0, 3'd7, 4'b0000, 64'h0000_0000_0000_00AB, 64'h0102_0304_0506_0708, 64'h0102_0304_0506_0708, 5'h01},
        '{2'd1, 3'd0, 3'd4, 4'b0010, 64'h0000_0000_CAFE_BABE, 64'h1111_1111_1111_1111, 64'h0000_0000_CAFE_BABE, 5'h05},
        '{2'd0, 3'd0, 3'd0, 4'b0001, 64'h0000_0000_0000_0077, 64'h2222_2222_2222_2222, 64'h0000_0000_0000_0077, 5'h03},
        '{2'd1, 3'd0, 3'd2, 4'b1100, 64'h0000_0000_0000_1234, 64'h0000_0000_0099_9999, 64'h0000_0000_0000_1234, 5'h19},
        '{2'd1, 3'd0, 3'd0, 4'b0000, 64'h0000_0000_0000_5555, 64'hAABB_CCDD_EEFF_0099, 64'h0000_0000_0000_0099, 5'h01}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [REG_AW-1:0] a, input logic [BUS_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [REG_AW-1:0] a, output logic [BUS_W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [BUS_W-1:0] v;
        v = 1;
        for (int i = 0; i < 200; i++) begin
            rd(OFF_BUSY, v);
            if (v == 0) break;
        end
        check("R5 busy clears", 64'(v), 64'h0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [BUS_W-1:0] v;
        int s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd(OFF_CLK_STD, v); check("R1 std clock", 64'(v), 64'h301F);
        rd(OFF_CLK_HS, v);  check("R1 hs clock", 64'(v), 64'h301F);
        rd(OFF_CFG, v);     check("R1 config", 64'(v), 64'h3302);
        rd(OFF_CMD, v);     check("R1 command", 64'(v), 64'h0);
        rd(OFF_ADDR, v);    check("R1 address", 64'(v), 64'h0);
        rd(OFF_DLO, v);     check("R1 data low", 64'(v), 64'h0);
        rd(OFF_DHI, v);     check("R1 data high", 64'(v), 64'h0);
        rd(OFF_STS, v);     check("R1 status", 64'(v), 64'h0);
        rd(OFF_MASK, v);    check("R1 mask", 64'(v), 64'h0);
        rd(OFF_BUSY, v);    check("R1 busy", 64'(v), 64'h0);
        check("R1 irq low", 64'(irq), 64'h0);

        // Table walk: R3 R5 R8 R9 R10 R6
        for (int k = 0; k < NV; k++) begin
            wr(OFF_DLO, VECS[k].wd[31:0]);
            wr(OFF_DHI, VECS[k].wd[63:32]);
            resp_flags = VECS[k].flg;
            resp_data  = VECS[k].rsp;
            s0 = n_start;
            wr(OFF_CMD, {22'b0, VECS[k].kind, 1'b0, VECS[k].wl, 1'b0, VECS[k].rl});
            rd(OFF_BUSY, v); check("R3 busy after launch", 64'(v), 64'h1);
            wait_idle();
            check("R3 one start", 64'(n_start - s0), 64'h1);
            check("R3 start kind", 64'(cap_kind), 64'(VECS[k].kind));
            check("R3 start wlen", 64'(cap_wl), 64'(VECS[k].wl));
            check("R3 start rlen", 64'(cap_rl), 64'(VECS[k].rl));
            check("R8 payload out", cap_wd, VECS[k].wd);
            rd(OFF_STS, v); check("R5 status flags", 64'(v), 64'(VECS[k].exp_s));
            rd(OFF_DLO, v); check("R9 R10 data low", 64'(v), 64'(VECS[k].exp_d[31:0]));
            rd(OFF_DHI, v); check("R9 R10 data high", 64'(v), 64'(VECS[k].exp_d[63:32]));
            wr(OFF_STS, 32'hFFFF_FFFF);
            rd(OFF_STS, v); check("R6 clear all", 64'(v), 64'h0);
        end

        // R2: field layout, reserved bits
        wr(OFF_CLK_STD, 32'hFFFF_FFFF);
        rd(OFF_CLK_STD, v); check("R2 std clock fields", 64'(v), 64'hF3FF);
        check("R2 std div port", 64'(std_div), 64'h3FF);
        wr(OFF_CLK_HS, 32'h0000_5123);
        rd(OFF_CLK_HS, v); check("R2 hs clock fields", 64'(v), 64'h5123);
        check("R2 hs filt port", 64'(hs_filt), 64'h5);
        wr(OFF_CFG, 32'hFFFF_FFFF);
        rd(OFF_CFG, v); check("R2 config fields", 64'(v), 64'hFFF3);
        wr(OFF_CFG, 32'h0000_3302);

        // R11: address width select
        wr(OFF_ADDR, 32'hFFFF_FFFF);
        rd(OFF_ADDR, v); check("R11 address readback", 64'(v), 64'h3FF);
        @(negedge clk); check("R11 seven-bit address", 64'(eng_addr), 64'h07F);
        wr(OFF_CFG, 32'h0000_3382);
        @(negedge clk); check("R11 ten-bit address", 64'(eng_addr), 64'h3FF);
        wr(OFF_CFG, 32'h0000_3302);

        // R4: command while busy ignored
        resp_delay = 20;
        resp_flags = '0;
        s0 = n_start;
        wr(OFF_CMD, 32'h0000_0020);
        wr(OFF_CMD, 32'h0000_0105);
        rd(OFF_CMD, v); check("R4 command kept while busy", 64'(v), 64'h20);
        wait_idle();
        check("R4 no second start", 64'(n_start - s0), 64'h1);
        resp_delay = 3;

        // R4: reserved type ignored
        s0 = n_start;
        wr(OFF_CMD, 32'h0000_0301);
        rd(OFF_BUSY, v); check("R4 reserved type stays idle", 64'(v), 64'h0);
        rd(OFF_CMD, v);  check("R4 reserved type command kept", 64'(v), 64'h20);
        repeat (6) @(negedge clk);
        check("R4 reserved type no start", 64'(n_start - s0), 64'h0);
        wr(OFF_STS, 32'h1F);

        // R7: masked interrupt
        wr(OFF_CMD, 32'h0000_0000);
        wait_idle();
        @(negedge clk); check("R7 irq off with zero mask", 64'(irq), 64'h0);
        wr(OFF_MASK, 32'h04);
        @(negedge clk); check("R7 irq off with other bit", 64'(irq), 64'h0);
        wr(OFF_MASK, 32'h01);
        @(negedge clk); check("R7 irq on", 64'(irq), 64'h1);
        wr(OFF_STS, 32'h01);
        @(negedge clk); check("R7 irq off after clear", 64'(irq), 64'h0);

        // R6: selective clear
        resp_flags = 4'b0011;
        wr(OFF_CMD, 32'h0000_0000);
        wait_idle();
        rd(OFF_STS, v); check("R5 two error flags", 64'(v), 64'h07);
        wr(OFF_STS, 32'h02);
        rd(OFF_STS, v); check("R6 selective clear", 64'(v), 64'h05);
        @(negedge clk); check("R7 irq done still masked in", 64'(irq), 64'h1);

        summary();
    end

endmodule